// File: doc/BRIEF.md
# Asynchronous Memory Bus Initiator

This block sits on the host side of a 16-bit asynchronous external memory and drives its pins. A local agent hands it one 32-bit read or write at a time through a valid/ready handshake, together with a 22-bit word address and a chip-select option. The block splits the word into two 16-bit bus phases, each with fixed timing: one setup cycle, a strobe held for a parameterised number of cycles, and one hold cycle. A bank-select field on the pins tells the target which half of the word is being moved.

For reads, the initiator samples the data bus in the last cycle of each output-enable window. It then puts the two halves together into a 32-bit word. A single-cycle done pulse marks the end of every access. Each request can ask for chip select to stay low once the access ends, so that the next access starts with no release of the select line in between.

Top module: `async_mem_init`

## Requirements
- R1: While reset is held, and at idle after reset, mem_cs_no, mem_we_no and mem_oe_no are 1, req_ready_o is 1, mem_dq_oe_o is 0, mem_be_no is 2'b11 and mem_ba_o is 2'b00.
- R2: req_ready_o is 1 only in idle. When req_valid_i and req_ready_o are both 1 at a rising edge, the request is taken and the next cycle is the first setup cycle of the access.
- R3: The first phase drives mem_ba_o = 2'b01 and carries word bits 15:0. The second phase drives mem_ba_o = 2'b10 and carries bits 31:16. mem_addr_o equals the request address in both phases.
- R4: Each phase is one setup cycle (chip select low, both strobes high), then STROBE_CYC cycles with the strobe low (mem_we_no for writes, mem_oe_no for reads), then one hold cycle with both strobes high. Address stays stable through all of these cycles.
- R5: In every cycle of a write phase, mem_dq_oe_o is 1 and mem_dq_o carries that phase's half of the word. During reads and idle, mem_dq_oe_o is 0.
- R6: A read samples mem_dq_i in the last cycle of each output-enable window. rdata_o returns the second phase's sample in bits 31:16 and the first phase's sample in bits 15:0.
- R7: mem_be_no is 2'b00 in every cycle of an access and 2'b11 in idle.
- R8: In the cycle after the second hold cycle and after it, until the next access, mem_cs_no is 0 if the request had req_keep_cs_i = 1, and 1 otherwise.
- R9: done_o is 1 for exactly one cycle: the cycle after the second hold cycle. In that cycle req_ready_o is also 1.
- R10: mem_we_no and mem_oe_no are never both 0. Neither one is 0 unless mem_cs_no is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted (idle) |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 22 | Word address |
| req_wdata_i | input | 32 | Write word |
| req_keep_cs_i | input | 1 | Keep chip select low after this access |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Assembled read word |
| mem_cs_no | output | 1 | Chip select, active low |
| mem_we_no | output | 1 | Write strobe, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_ba_o | output | 2 | Half-word bank select |
| mem_addr_o | output | 22 | External address |
| mem_be_no | output | 2 | Byte mask, active low |
| mem_dq_o | output | 16 | Data driven to the bus |
| mem_dq_oe_o | output | 1 | Data driver enable |
| mem_dq_i | input | 16 | Data sampled from the bus |

## Verification
The bench's target drives valid read data only in the last cycle of each output-enable window and drives junk in every other cycle. A design that samples one cycle early, or after the release, returns a corrupted word. The two halves are given different patterns, so swapped bank selects or swapped halves show up as mismatches in the pin data and in rdata_o. Accesses alternate between keeping and releasing chip select, with idle gaps between them. A design that applies the chip-select choice at the wrong time, or forgets it, gives the wrong mem_cs_no in the done cycle or in later idle cycles. Every strobe window is also counted: an off-by-one in the strobe counter gives one cycle too many or too few of low strobe.

// File: rtl/async_mem_pkg.sv
package async_mem_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } amem_state_e;
endpackage

// File: rtl/async_mem_seq.sv
module async_mem_seq
  import async_mem_pkg::*;
#(
  parameter int unsigned STROBE_CYC = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  output amem_state_e state_o,
  output logic        phase_o,
  output logic        cap_o,
  output logic        fin_o
);
  localparam int unsigned CNT_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CYC - 1);

  amem_state_e      state_q, state_d;
  logic             phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last_strobe;

  assign last_strobe = (state_q == ST_STROBE) && (cnt_q == CNT_LAST);

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_SETUP;
        phase_d = 1'b0;
      end
      ST_SETUP: begin
        state_d = ST_STROBE;
        cnt_d   = '0;
      end
      ST_STROBE: begin
        if (last_strobe) state_d = ST_HOLD;
        else             cnt_d   = cnt_q + 1'b1;
      end
      ST_HOLD: begin
        if (!phase_q) begin
          state_d = ST_SETUP;
          phase_d = 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
  assign phase_o = phase_q;
  assign cap_o   = last_strobe;
  assign fin_o   = (state_q == ST_HOLD) && phase_q;
endmodule

// File: rtl/async_mem_rdcap.sv
module async_mem_rdcap #(
  parameter int unsigned DQ_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cap_i,
  input  logic            phase_i,
  input  logic [DQ_W-1:0] dq_i,
  output logic [2*DQ_W-1:0] word_o
);
  logic [1:0][DQ_W-1:0] half_q;

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          half_q[h] <= '0;
      else if (cap_i && (phase_i == h[0])) half_q[h] <= dq_i;
    end
  end

  assign word_o = half_q;
endmodule

// File: rtl/async_mem_pins.sv
module async_mem_pins
  import async_mem_pkg::*;
#(
  parameter int unsigned ADDR_W = 22,
  parameter int unsigned DQ_W   = 16
) (
  input  amem_state_e         state_i,
  input  logic                phase_i,
  input  logic                we_i,
  input  logic                cs_hold_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [2*DQ_W-1:0]   wdata_i,
  output logic                cs_no,
  output logic                we_no,
  output logic                oe_no,
  output logic [1:0]          ba_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [DQ_W/8-1:0]   be_no,
  output logic [DQ_W-1:0]     dq_o,
  output logic                dq_oe_o
);
  logic busy, strobe;

  assign busy    = (state_i != ST_IDLE);
  assign strobe  = (state_i == ST_STROBE);
  assign cs_no   = !(busy || cs_hold_i);
  assign we_no   = !(strobe && we_i);
  assign oe_no   = !(strobe && !we_i);
  assign ba_o    = !busy ? 2'b00 : (phase_i ? 2'b10 : 2'b01);
  assign addr_o  = addr_i;
  assign be_no   = busy ? '0 : '1;
  assign dq_oe_o = busy && we_i;
  assign dq_o    = phase_i ? wdata_i[2*DQ_W-1:DQ_W] : wdata_i[DQ_W-1:0];
endmodule

// File: rtl/async_mem_init.sv
module async_mem_init
  import async_mem_pkg::*;
#(
  parameter int unsigned ADDR_W     = 22,
  parameter int unsigned DQ_W       = 16,
  parameter int unsigned STROBE_CYC = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_we_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [2*DQ_W-1:0]   req_wdata_i,
  input  logic                req_keep_cs_i,
  output logic                done_o,
  output logic [2*DQ_W-1:0]   rdata_o,
  output logic                mem_cs_no,
  output logic                mem_we_no,
  output logic                mem_oe_no,
  output logic [1:0]          mem_ba_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DQ_W/8-1:0]   mem_be_no,
  output logic [DQ_W-1:0]     mem_dq_o,
  output logic                mem_dq_oe_o,
  input  logic [DQ_W-1:0]     mem_dq_i
);
  amem_state_e         state;
  logic                phase, cap, fin, start;
  logic                we_q, keep_q, cs_hold_q, done_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [2*DQ_W-1:0]   wdata_q;

  assign req_ready_o = (state == ST_IDLE);
  assign start       = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q      <= 1'b0;
      keep_q    <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      cs_hold_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      if (start) begin
        we_q    <= req_we_i;
        keep_q  <= req_keep_cs_i;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
      if (fin) cs_hold_q <= keep_q;  // select decision lands after final hold
      done_q <= fin;
    end
  end

  async_mem_seq #(.STROBE_CYC(STROBE_CYC)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .state_o (state),
    .phase_o (phase),
    .cap_o   (cap),
    .fin_o   (fin)
  );

  async_mem_rdcap #(.DQ_W(DQ_W)) u_rdcap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap && !we_q),
    .phase_i (phase),
    .dq_i    (mem_dq_i),
    .word_o  (rdata_o)
  );

  async_mem_pins #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_pins (
    .state_i   (state),
    .phase_i   (phase),
    .we_i      (we_q),
    .cs_hold_i (cs_hold_q),
    .addr_i    (addr_q),
    .wdata_i   (wdata_q),
    .cs_no     (mem_cs_no),
    .we_no     (mem_we_no),
    .oe_no     (mem_oe_no),
    .ba_o      (mem_ba_o),
    .addr_o    (mem_addr_o),
    .be_no     (mem_be_no),
    .dq_o      (mem_dq_o),
    .dq_oe_o   (mem_dq_oe_o)
  );

  assign done_o = done_q;
endmodule

// File: rtl/async_mem_init_chk.sv
module async_mem_init_chk #(
  parameter int unsigned ADDR_W     = 22,
  parameter int unsigned DQ_W       = 16,
  parameter int unsigned STROBE_CYC = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              done_o,
  input logic              mem_cs_no,
  input logic              mem_we_no,
  input logic              mem_oe_no,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DQ_W/8-1:0] mem_be_no,
  input logic              mem_dq_oe_o
);
  int unsigned we_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         we_run_q <= 0;
    else if (!mem_we_no) we_run_q <= we_run_q + 1;
    else                 we_run_q <= 0;
  end

  a_r10_no_dual_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_we_no && !mem_oe_no));
  a_r10_strobe_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_no || !mem_oe_no) |-> !mem_cs_no);
  a_r2_accept_to_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (!req_ready_o && !mem_cs_no && mem_we_no && mem_oe_no));
  a_r4_we_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (we_run_q == STROBE_CYC));
  a_r4_addr_stable_at_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> $stable(mem_addr_o));
  a_r5_no_drive_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> !mem_dq_oe_o);
  a_r7_mask_in_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |-> (mem_be_no == '0));
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_done_with_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o);
endmodule

bind async_mem_init async_mem_init_chk #(
  .ADDR_W(ADDR_W), .DQ_W(DQ_W), .STROBE_CYC(STROBE_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .done_o      (done_o),
  .mem_cs_no   (mem_cs_no),
  .mem_we_no   (mem_we_no),
  .mem_oe_no   (mem_oe_no),
  .mem_addr_o  (mem_addr_o),
  .mem_be_no   (mem_be_no),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/async_mem_init_bench.sv
module async_mem_init_bench;
  localparam int STB = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0, req_keep = 1'b0;
  logic [21:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, done;
  logic [31:0] rdata;
  logic        cs_n, we_n, oe_n, dq_oe;
  logic [1:0]  ba, be_n;
  logic [21:0] addr;
  logic [15:0] dq_o, dq_i;
  logic [7:0]  oe_run = '0;
  logic [15:0] salt = 16'h0000;

  int checks = 0, errors = 0;
  bit started = 0;

  typedef struct packed {
    logic        cs_n, we_n, oe_n;
    logic [1:0]  ba;
    logic [21:0] addr;
    logic        chk_addr;
    logic [1:0]  be_n;
    logic        dq_oe;
    logic [15:0] dq;
    logic        ready, done;
  } cyc_t;

  cyc_t exp_q[$];
  logic keep_last = 1'b0;

  always #5 clk = ~clk;

  async_mem_init u_async_mem_init (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_keep_cs_i(req_keep),
    .done_o(done), .rdata_o(rdata),
    .mem_cs_no(cs_n), .mem_we_no(we_n), .mem_oe_no(oe_n), .mem_ba_o(ba),
    .mem_addr_o(addr), .mem_be_no(be_n), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe),
    .mem_dq_i(dq_i)
  );

  function automatic logic [15:0] half_val(logic [21:0] a, logic [1:0] b, logic [15:0] s);
    return {a[7:0], a[15:8]} ^ ((b == 2'b01) ? 16'h3C5A : 16'hA5C3) ^ s;
  endfunction

  // target: valid data only in the final output-enable cycle
  always @(posedge clk) oe_run <= oe_n ? 8'd0 : oe_run + 8'd1;
  assign dq_i = (!oe_n && oe_run == 8'(STB - 1)) ? half_val(addr, ba, salt)
                                                 : (16'hBAD0 ^ {8'h00, oe_run});

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic cyc_t mk(logic c, logic w, logic o, logic [1:0] b, logic [21:0] a,
                              logic ca, logic [1:0] be, logic de, logic [15:0] d,
                              logic r, logic dn);
    cyc_t e;
    e.cs_n = c; e.we_n = w; e.oe_n = o; e.ba = b; e.addr = a; e.chk_addr = ca;
    e.be_n = be; e.dq_oe = de; e.dq = d; e.ready = r; e.done = dn;
    return e;
  endfunction

  task automatic push_req(input logic w, input logic [21:0] a, input logic [31:0] wd, input logic k);
    for (int ph = 0; ph < 2; ph++) begin
      logic [1:0]  b = (ph == 0) ? 2'b01 : 2'b10;
      logic [15:0] h = (ph == 0) ? wd[15:0] : wd[31:16];
      exp_q.push_back(mk(0, 1, 1, b, a, 1, 2'b00, w, h, 0, 0));
      for (int s = 0; s < STB; s++)
        exp_q.push_back(mk(0, !w, w, b, a, 1, 2'b00, w, h, 0, 0));
      exp_q.push_back(mk(0, 1, 1, b, a, 1, 2'b00, w, h, 0, 0));
    end
    exp_q.push_back(mk(!k, 1, 1, 2'b00, '0, 0, 2'b11, 0, '0, 1, 1));
  endtask

  // cycle reference compare
  always @(negedge clk) begin
    if (started && rst_n) begin
      cyc_t e;
      if (exp_q.size() > 0) e = exp_q.pop_front();
      else e = mk(!keep_last, 1, 1, 2'b00, '0, 0, 2'b11, 0, '0, 1, 0);
      if (e.done) keep_last = !e.cs_n;
      chk(e.ready ? "R8 cs_n idle" : "R4 cs_n access", {31'd0, cs_n}, {31'd0, e.cs_n});
      chk("R4 we_n", {31'd0, we_n}, {31'd0, e.we_n});
      chk("R4 oe_n", {31'd0, oe_n}, {31'd0, e.oe_n});
      chk("R3 ba", {30'd0, ba}, {30'd0, e.ba});
      if (e.chk_addr) chk("R3 addr", {10'd0, addr}, {10'd0, e.addr});
      chk("R7 be_n", {30'd0, be_n}, {30'd0, e.be_n});
      chk("R5 dq_oe", {31'd0, dq_oe}, {31'd0, e.dq_oe});
      if (e.dq_oe) chk("R5 dq_o", {16'd0, dq_o}, {16'd0, e.dq});
      chk("R2 ready", {31'd0, req_ready}, {31'd0, e.ready});
      chk("R9 done", {31'd0, done}, {31'd0, e.done});
      chk("R10 strobes", {31'd0, (!we_n && !oe_n) || ((!we_n || !oe_n) && cs_n)}, 32'd0);
      if (req_ready && req_valid) push_req(req_we, req_addr, req_wdata, req_keep);
    end
  end

  task automatic do_req(input logic w, input logic [21:0] a, input logic [31:0] wd,
                        input logic k, output logic [31:0] rd);
    @(posedge clk); #1;
    req_valid = 1; req_we = w; req_addr = a; req_wdata = wd; req_keep = k;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 0; req_wdata = 32'hFFFF_FFFF; req_addr = ~a;
    do @(negedge clk); while (!done);
    rd = rdata;
  endtask

  task automatic do_read(input logic [21:0] a, input logic k, input logic [15:0] s);
    logic [31:0] rd;
    salt = s;
    do_req(0, a, '0, k, rd);
    chk("R6 rdata", rd, {half_val(a, 2'b10, s), half_val(a, 2'b01, s)});
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (2) @(negedge clk);
    chk("R1 cs_n", {31'd0, cs_n}, 32'd1);
    chk("R1 we_n/oe_n", {30'd0, we_n, oe_n}, 32'd3);
    chk("R1 dq_oe", {31'd0, dq_oe}, 32'd0);
    chk("R1 be_n/ba", {28'd0, be_n, ba}, 32'hC);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", {31'd0, req_ready}, 32'd1);
    started = 1;
    do_req(1, 22'h000123, 32'hDEAD_BEEF, 0, rd);
    repeat (2) @(posedge clk);
    do_req(1, 22'h3FFFFF, 32'h1234_5678, 1, rd);
    repeat (3) @(posedge clk);
    do_read(22'h000123, 1, 16'h0000);
    do_read(22'h2A5A5A, 0, 16'h5AA5);
    repeat (2) @(posedge clk);
    do_req(1, 22'h000000, 32'h0000_FFFF, 1, rd);
    do_read(22'h155555, 1, 16'hFFFF);
    do_req(1, 22'h0ABCDE, 32'hA5A5_5A5A, 0, rd);
    do_read(22'h000001, 0, 16'h1357);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R9 no pending", exp_q.size(), 32'd0);
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule